// File: doc/BRIEF.md
# DDR SDRAM Command and Power-State Tracker

This block is the synchronous command front end of a DDR-style SDRAM device. At every rising clock edge it samples chip select, the three command strobes, clock enable, the bank-address bits and the address bus. It turns that sample into a one-hot command strobe and presents the target bank, the row address, column address or mode op-code, and the flags carried on the address bus. It keeps one open-row flag per bank. Downstream array and refresh logic take the decoded strobe and address fields from this block, and use the reported power state and buffer enables to gate their own activity.

Clock enable drives a power-state machine. Dropping CKE from normal operation enters one of three low-power states. Self refresh is chosen if a refresh command is sampled on the same edge. Otherwise the block enters active power-down when any bank has an open row, and precharge power-down when none does. Leaving power-down, and entering either low-power state, happens on a clock edge. Leaving self refresh is reported as soon as CKE rises, with no clock edge needed, because the clock may be stopped while the device is in self refresh. No command is decoded while the block is in a low-power state, or on the edge where it enters or leaves one.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: A command sampled with `cs_n` high is masked. No strobe rises and no bank flag changes.
- R2: With `cs_n` low, CKE high and the block in normal state, the code {`ras_n`,`cas_n`,`we_n`} selects one bit of `cmd_strobe` in the cycle after the sampling edge. The mapping is: 011 sets bit 0 (activate), 101 sets bit 1 (read), 100 sets bit 2 (write), 010 sets bit 3 (precharge), 001 sets bit 4 (refresh), 000 sets bit 5 (mode load) and 110 sets bit 6 (burst stop). Code 111 sets no bit. At most one bit is ever high.
- R3: Activate sets `bank_open[ba]`, reports `cmd_bank`=`ba`, and reports `cmd_addr` equal to the full address bus as the row.
- R4: Read and write report `cmd_bank`=`ba`, report `cmd_addr` as the address bus with bit 10 cleared, and report `auto_pre` equal to address bit 10. When bit 10 is set, the addressed bank's open flag is cleared.
- R5: Precharge with address bit 10 low clears only `bank_open[ba]`. With address bit 10 high it clears every flag and raises `pre_all`. In both cases `cmd_addr` is zero.
- R6: Mode load reports the address bus as the op-code on `cmd_addr`, reports `cmd_bank`=`ba`, and sets `mode_ext` equal to `ba[0]`: 0 selects the base register and 1 selects the extended register.
- R7: CKE sampled low in normal state with no bank open and no refresh code moves `pwr_state` to 1 (precharge power-down).
- R8: CKE sampled low in normal state with any bank open and no refresh code moves `pwr_state` to 2 (active power-down).
- R9: CKE sampled low in normal state together with the refresh code (`cs_n` low, 001) moves `pwr_state` to 3 (self refresh).
- R10: In either power-down state, CKE sampled high returns `pwr_state` to 0 (normal). The command sampled on that exit edge is ignored, and commands are decoded again from the next edge.
- R11: In self refresh, a rising CKE makes `pwr_state` read 0 and raises both buffer enables before any clock edge. The command sampled on the first edge after the exit is ignored.
- R12: `inbuf_en` is high only in normal state. `clkbuf_en` is low only in self refresh.
- R13: No strobe rises for a command sampled in a low-power state or on the edge that enters one. Holding `rst_n` low across a clock edge gives normal state, all banks closed and all command outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write-enable command bit |
| ba | input | 2 | Bank address / mode-register select |
| addr | input | 12 | Row, column, op-code and flag bus |
| cmd_strobe | output | 7 | One-hot decoded command |
| cmd_bank | output | 2 | Target bank of decoded command |
| cmd_addr | output | 12 | Row, column or op-code |
| auto_pre | output | 1 | Read/write requested auto-precharge |
| pre_all | output | 1 | Precharge applies to all banks |
| mode_ext | output | 1 | Mode load targets the extended register |
| bank_open | output | 4 | Per-bank open-row flags |
| pwr_state | output | 2 | 0 normal, 1 precharge PD, 2 active PD, 3 self refresh |
| inbuf_en | output | 1 | Command/address input buffers enabled |
| clkbuf_en | output | 1 | Clock input buffer enabled |

## Verification
The bench walks through all command codes with chip select both low and high, and targets different banks. A decoder that ignores chip select would report a strobe or open a bank on a masked cycle. One that mis-cracks address bit 10 would close the wrong banks, or leave the flag bit inside the column. The bench drives CKE low with and without an open row and with the refresh code, so that a wrong choice of low-power state shows up on `pwr_state`. It checks that commands sampled in power-down and on the exit edge are dropped, because a design that decoded them would open a bank while asleep. Self-refresh exit is observed between clock edges, before the next rising edge, which catches a design that waits for the clock. A reset from inside active power-down with open banks confirms that the synchronous reset clears everything.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

   typedef enum logic [1:0] {
      PWR_NORMAL   = 2'd0,
      PWR_PRE_PD   = 2'd1,
      PWR_ACT_PD   = 2'd2,
      PWR_SELF_REF = 2'd3
   } pwr_state_e;

   localparam int CMD_N  = 7;
   localparam int CI_ACT = 0;
   localparam int CI_RD  = 1;
   localparam int CI_WR  = 2;
   localparam int CI_PRE = 3;
   localparam int CI_REF = 4;
   localparam int CI_MRS = 5;
   localparam int CI_BST = 6;

   // {ras_n, cas_n, we_n} with chip select low
   localparam logic [2:0] OP_NOP = 3'b111;
   localparam logic [2:0] OP_ACT = 3'b011;
   localparam logic [2:0] OP_RD  = 3'b101;
   localparam logic [2:0] OP_WR  = 3'b100;
   localparam logic [2:0] OP_PRE = 3'b010;
   localparam logic [2:0] OP_REF = 3'b001;
   localparam logic [2:0] OP_MRS = 3'b000;
   localparam logic [2:0] OP_BST = 3'b110;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_trk_pkg::*;
(
   input  logic             en,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   output logic [CMD_N-1:0] strobe,
   output logic             ref_code
);

   logic [2:0] code;
   assign code = {ras_n, cas_n, we_n};

   // refresh code is reported regardless of enable: power FSM needs it on CKE fall
   assign ref_code = !cs_n && (code == OP_REF);

   always_comb begin
      strobe = '0;
      if (en && !cs_n) begin
         case (code)
            OP_ACT:  strobe[CI_ACT] = 1'b1;
            OP_RD:   strobe[CI_RD]  = 1'b1;
            OP_WR:   strobe[CI_WR]  = 1'b1;
            OP_PRE:  strobe[CI_PRE] = 1'b1;
            OP_REF:  strobe[CI_REF] = 1'b1;
            OP_MRS:  strobe[CI_MRS] = 1'b1;
            OP_BST:  strobe[CI_BST] = 1'b1;
            default: strobe = '0;
         endcase
      end
   end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
   parameter int BANKS = 4,
   parameter int BA_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             close_one,
   input  logic             close_all,
   input  logic [BA_W-1:0]  ba,
   output logic [BANKS-1:0] open_q
);

   for (genvar g = 0; g < BANKS; g++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)
            open_q[g] <= 1'b0;
         else if (open_set && hit)
            open_q[g] <= 1'b1;
         else if (close_all || (close_one && hit))
            open_q[g] <= 1'b0;
      end
   end

   // R3
   act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_set |=> open_q[$past(ba)]);

   // R5
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close_all |=> (open_q == '0));

   // R4
   close_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (close_one && !open_set) |=> !open_q[$past(ba)]);

endmodule

// File: rtl/ddr_pwr_fsm.sv
module ddr_pwr_fsm
   import ddr_trk_pkg::*;
#(
   parameter bit ASYNC_SR_EXIT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic       ref_code,
   input  logic       any_open,
   output pwr_state_e state_q,
   output pwr_state_e eff_state,
   output logic       cmd_en,
   output logic       inbuf_en,
   output logic       clkbuf_en
);

   pwr_state_e state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         PWR_NORMAL:
            if (!cke) begin
               if (ref_code)      state_d = PWR_SELF_REF;
               else if (any_open) state_d = PWR_ACT_PD;
               else               state_d = PWR_PRE_PD;
            end
         PWR_PRE_PD, PWR_ACT_PD, PWR_SELF_REF:
            if (cke) state_d = PWR_NORMAL;
         default: state_d = PWR_NORMAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= PWR_NORMAL;
      else        state_q <= state_d;
   end

   if (ASYNC_SR_EXIT) begin : g_async_exit
      assign eff_state = (state_q == PWR_SELF_REF && cke) ? PWR_NORMAL : state_q;
   end else begin : g_sync_exit
      assign eff_state = state_q;
   end

   assign cmd_en    = (state_q == PWR_NORMAL) && cke;
   assign inbuf_en  = (eff_state == PWR_NORMAL);
   assign clkbuf_en = (eff_state != PWR_SELF_REF);

   // R7
   pre_pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PWR_NORMAL && !cke && !ref_code && !any_open) |=> (state_q == PWR_PRE_PD));

   // R8
   act_pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PWR_NORMAL && !cke && !ref_code && any_open) |=> (state_q == PWR_ACT_PD));

   // R9
   sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PWR_NORMAL && !cke && ref_code) |=> (state_q == PWR_SELF_REF));

   // R10
   pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PWR_PRE_PD || state_q == PWR_ACT_PD) && cke) |=> (state_q == PWR_NORMAL));

   // R11
   sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PWR_SELF_REF && cke) |=> (state_q == PWR_NORMAL));

   // R10
   pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PWR_NORMAL && !cke) |=> $stable(state_q));

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
   import ddr_trk_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int BANKS         = 4,
   parameter int AP_BIT        = 10,
   parameter bit ASYNC_SR_EXIT = 1'b1,
   localparam int BA_W         = $clog2(BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic [CMD_N-1:0]  cmd_strobe,
   output logic [BA_W-1:0]   cmd_bank,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              auto_pre,
   output logic              pre_all,
   output logic              mode_ext,
   output logic [BANKS-1:0]  bank_open,
   output logic [1:0]        pwr_state,
   output logic              inbuf_en,
   output logic              clkbuf_en
);

   localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("auto-precharge bit lies outside the address bus");
   end
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("bank count must be a power of two, at least 2");
   end

   logic             cmd_en;
   logic             ref_code;
   logic [CMD_N-1:0] dec;
   logic             a_flag;
   pwr_state_e       fsm_q;
   pwr_state_e       fsm_eff;

   assign a_flag = addr[AP_BIT];

   ddr_cmd_decode u_dec (
      .en       (cmd_en),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .strobe   (dec),
      .ref_code (ref_code)
   );

   ddr_pwr_fsm #(
      .ASYNC_SR_EXIT (ASYNC_SR_EXIT)
   ) u_pwr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .ref_code  (ref_code),
      .any_open  (|bank_open),
      .state_q   (fsm_q),
      .eff_state (fsm_eff),
      .cmd_en    (cmd_en),
      .inbuf_en  (inbuf_en),
      .clkbuf_en (clkbuf_en)
   );

   ddr_bank_track #(
      .BANKS (BANKS),
      .BA_W  (BA_W)
   ) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_set  (dec[CI_ACT]),
      .close_one ((dec[CI_PRE] && !a_flag) || ((dec[CI_RD] || dec[CI_WR]) && a_flag)),
      .close_all (dec[CI_PRE] && a_flag),
      .ba        (ba),
      .open_q    (bank_open)
   );

   assign pwr_state = fsm_eff;

   logic has_bank;
   logic is_rw;
   assign has_bank = dec[CI_ACT] | dec[CI_RD] | dec[CI_WR] | dec[CI_PRE] | dec[CI_MRS];
   assign is_rw    = dec[CI_RD] | dec[CI_WR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_strobe <= '0;
         cmd_bank   <= '0;
         cmd_addr   <= '0;
         auto_pre   <= 1'b0;
         pre_all    <= 1'b0;
         mode_ext   <= 1'b0;
      end else begin
         cmd_strobe <= dec;
         cmd_bank   <= has_bank ? ba : '0;
         if (dec[CI_ACT] || dec[CI_MRS]) cmd_addr <= addr;
         else if (is_rw)                 cmd_addr <= addr & ~AP_MASK;
         else                            cmd_addr <= '0;
         auto_pre   <= is_rw && a_flag;
         pre_all    <= dec[CI_PRE] && a_flag;
         mode_ext   <= dec[CI_MRS] && ba[0];
      end
   end

   // R1
   cs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cmd_strobe == '0));

   // R2
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_strobe));

   // R13
   lowpwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_q != PWR_NORMAL || !cke) |=> (cmd_strobe == '0));

   // R12
   buf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strobe != '0) |-> $past(inbuf_en));

endmodule

// File: tb/ddr_cmd_tracker_test.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cke, cs_n, ras_n, cas_n, we_n;
   logic [1:0]  ba;
   logic [11:0] addr;
   logic [6:0]  cmd_strobe;
   logic [1:0]  cmd_bank;
   logic [11:0] cmd_addr;
   logic        auto_pre, pre_all, mode_ext;
   logic [3:0]  bank_open;
   logic [1:0]  pwr_state;
   logic        inbuf_en, clkbuf_en;

   int n_run  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   ddr_cmd_tracker uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .cmd_strobe(cmd_strobe), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
      .auto_pre(auto_pre), .pre_all(pre_all), .mode_ext(mode_ext),
      .bank_open(bank_open), .pwr_state(pwr_state),
      .inbuf_en(inbuf_en), .clkbuf_en(clkbuf_en)
   );

   typedef struct packed {
      logic        cke;
      logic        cs_n;
      logic [2:0]  op;
      logic [1:0]  ba;
      logic [11:0] addr;
      logic [6:0]  e_stb;
      logic [1:0]  e_bank;
      logic [11:0] e_addr;
      logic        e_ap;
      logic        e_pall;
      logic        e_msel;
      logic [3:0]  e_open;
      logic [1:0]  e_pwr;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b0,3'b111,2'd0,12'h000, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd0,4'd2},  // R2 nop
      '{1'b1,1'b0,3'b011,2'd1,12'h5A5, 7'b0000001,2'd1,12'h5A5,1'b0,1'b0,1'b0,4'b0010,2'd0,4'd3},  // R3
      '{1'b1,1'b1,3'b011,2'd2,12'h333, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0010,2'd0,4'd1},  // R1
      '{1'b1,1'b0,3'b101,2'd1,12'h4AB, 7'b0000010,2'd1,12'h0AB,1'b1,1'b0,1'b0,4'b0000,2'd0,4'd4},  // R4
      '{1'b1,1'b0,3'b011,2'd3,12'h123, 7'b0000001,2'd3,12'h123,1'b0,1'b0,1'b0,4'b1000,2'd0,4'd3},  // R3
      '{1'b1,1'b0,3'b100,2'd3,12'h0FF, 7'b0000100,2'd3,12'h0FF,1'b0,1'b0,1'b0,4'b1000,2'd0,4'd4},  // R4
      '{1'b1,1'b0,3'b011,2'd0,12'h7FF, 7'b0000001,2'd0,12'h7FF,1'b0,1'b0,1'b0,4'b1001,2'd0,4'd3},  // R3
      '{1'b1,1'b0,3'b010,2'd0,12'h000, 7'b0001000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b1000,2'd0,4'd5},  // R5
      '{1'b1,1'b0,3'b011,2'd1,12'h001, 7'b0000001,2'd1,12'h001,1'b0,1'b0,1'b0,4'b1010,2'd0,4'd3},  // R3
      '{1'b1,1'b0,3'b010,2'd2,12'h400, 7'b0001000,2'd2,12'h000,1'b0,1'b1,1'b0,4'b0000,2'd0,4'd5},  // R5
      '{1'b1,1'b0,3'b000,2'd0,12'h032, 7'b0100000,2'd0,12'h032,1'b0,1'b0,1'b0,4'b0000,2'd0,4'd6},  // R6
      '{1'b1,1'b0,3'b000,2'd1,12'h002, 7'b0100000,2'd1,12'h002,1'b0,1'b0,1'b1,4'b0000,2'd0,4'd6},  // R6
      '{1'b1,1'b0,3'b001,2'd0,12'h000, 7'b0010000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd0,4'd2},  // R2
      '{1'b1,1'b0,3'b110,2'd0,12'h000, 7'b1000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd0,4'd2},  // R2
      '{1'b0,1'b0,3'b111,2'd0,12'h000, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd1,4'd7},  // R7
      '{1'b0,1'b0,3'b011,2'd0,12'h010, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd1,4'd13}, // R13
      '{1'b1,1'b0,3'b011,2'd0,12'h010, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd0,4'd10}, // R10
      '{1'b1,1'b0,3'b011,2'd2,12'h0AA, 7'b0000001,2'd2,12'h0AA,1'b0,1'b0,1'b0,4'b0100,2'd0,4'd10}, // R10
      '{1'b0,1'b0,3'b111,2'd0,12'h000, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0100,2'd2,4'd8},  // R8
      '{1'b0,1'b0,3'b101,2'd2,12'h400, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0100,2'd2,4'd13}, // R13
      '{1'b1,1'b0,3'b111,2'd0,12'h000, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0100,2'd0,4'd10}, // R10
      '{1'b1,1'b0,3'b010,2'd0,12'h400, 7'b0001000,2'd0,12'h000,1'b0,1'b1,1'b0,4'b0000,2'd0,4'd5},  // R5
      '{1'b0,1'b0,3'b001,2'd0,12'h000, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd3,4'd9},  // R9
      '{1'b0,1'b0,3'b111,2'd0,12'h000, 7'b0000000,2'd0,12'h000,1'b0,1'b0,1'b0,4'b0000,2'd3,4'd9}   // R9
   };

   task automatic drive(input logic k, input logic c, input logic [2:0] op,
                        input logic [1:0] b, input logic [11:0] a);
      cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = b; addr = a;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                      input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [63:0] outs();
      return {cmd_strobe, cmd_bank, cmd_addr, auto_pre, pre_all, mode_ext,
              bank_open, pwr_state, inbuf_en, clkbuf_en};
   endfunction

   initial begin
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b1, 1'b1, 3'b111, 2'd0, 12'h000);
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(outs() == {7'd0,2'd0,12'd0,3'b000,4'b0000,2'd0,2'b11}, "R13 reset", outs(),
          {7'd0,2'd0,12'd0,3'b000,4'b0000,2'd0,2'b11});
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [63:0] exp;
         drive(VEC[i].cke, VEC[i].cs_n, VEC[i].op, VEC[i].ba, VEC[i].addr);
         @(negedge clk);
         exp = {VEC[i].e_stb, VEC[i].e_bank, VEC[i].e_addr, VEC[i].e_ap,
                VEC[i].e_pall, VEC[i].e_msel, VEC[i].e_open, VEC[i].e_pwr,
                VEC[i].e_pwr == 2'd0, VEC[i].e_pwr != 2'd3};
         chk(outs() == exp, $sformatf("R%0d vector %0d", VEC[i].req, i), outs(), exp);
      end

      // R12 in self refresh both buffer enables low
      chk({inbuf_en, clkbuf_en} == 2'b00, "R12 self-refresh buffers", {inbuf_en, clkbuf_en}, 2'b00);

      // R11 asynchronous exit seen before the next rising edge
      drive(1'b1, 1'b0, 3'b011, 2'd1, 12'h005);
      #1;
      chk({pwr_state, inbuf_en, clkbuf_en} == 4'b0011, "R11 async exit",
          {pwr_state, inbuf_en, clkbuf_en}, 4'b0011);
      @(negedge clk);
      // R11 command on first edge after exit ignored
      chk({cmd_strobe, bank_open, pwr_state} == {7'd0, 4'b0000, 2'd0}, "R11 exit edge ignored",
          {cmd_strobe, bank_open, pwr_state}, {7'd0, 4'b0000, 2'd0});
      @(negedge clk);
      chk({cmd_strobe, bank_open} == {7'b0000001, 4'b0010}, "R11 decode after exit",
          {cmd_strobe, bank_open}, {7'b0000001, 4'b0010});

      // R12 active power-down: clock buffer on, input buffers off
      drive(1'b0, 1'b0, 3'b111, 2'd0, 12'h000);
      @(negedge clk);
      chk({pwr_state, inbuf_en, clkbuf_en} == 4'b1001, "R12 power-down buffers",
          {pwr_state, inbuf_en, clkbuf_en}, 4'b1001);

      // R13 synchronous reset from active power-down with a bank open
      rst_n = 1'b0;
      @(negedge clk);
      chk(outs() == {7'd0,2'd0,12'd0,3'b000,4'b0000,2'd0,2'b11}, "R13 reset from power-down",
          outs(), {7'd0,2'd0,12'd0,3'b000,4'b0000,2'd0,2'b11});
      rst_n = 1'b1;
      drive(1'b1, 1'b0, 3'b011, 2'd3, 12'h00F);
      @(negedge clk);
      chk({cmd_strobe, bank_open, pwr_state} == {7'b0000001, 4'b1000, 2'd0}, "R13 decode after reset",
          {cmd_strobe, bank_open, pwr_state}, {7'b0000001, 4'b1000, 2'd0});

      // R1 masked refresh with CKE high: no strobe
      drive(1'b1, 1'b1, 3'b001, 2'd0, 12'h000);
      @(negedge clk);
      chk(cmd_strobe == 7'd0, "R1 masked refresh", cmd_strobe, 7'd0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule